// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit computes the operand location for a load/store style processor pipeline. Each request supplies a 3-bit mode code, two register indices, a 14-bit signed offset field, the current program counter and an operand-size code. The unit presents the two indices on a pair of combinational register-file read ports. One clock later it returns a registered result. That result is either a memory address or an operand value that needs no memory access, plus a flag that tells which of the two it is.

For the post-increment and pre-decrement pointer modes, the unit also issues a single-cycle write-back strobe. The strobe carries the register index and the updated pointer, so the register file can store the advanced pointer. The pointer step depends on the operand size.

Eight mode codes serve the following modes:
- immediate
- register
- absolute
- PC-relative
- offset-plus-register
- two-register sum with offset
- post-increment
- pre-decrement

A zero offset turns the offset-plus-register code into register-indirect addressing. It also turns the two-register-with-offset code into plain base-plus-index addressing.

Top module: `eagu_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `out_valid`, `out_mem` and `wb_en` are 0, and `out_value` and `wb_data` are 0.
- R2: A request sampled with `req_valid` high at a rising edge produces `out_valid` high after that same edge. A cycle without a request leaves `out_valid` low after the next edge.
- R3: Mode code 0 (immediate) returns the 14-bit offset field sign-extended to 32 bits, with `out_mem` = 0.
- R4: Mode code 1 (register) returns the content of the register named by `idx_a`, with `out_mem` = 0.
- R5: Mode code 2 (absolute) returns the offset field zero-extended as the address, with `out_mem` = 1.
- R6: Mode code 3 (relative) returns `pc` plus the sign-extended offset, so the target can lie before or after `pc`; `out_mem` = 1.
- R7: Mode code 4 (index) returns register `idx_a` plus the sign-extended offset, with `out_mem` = 1. A zero offset gives register-indirect addressing.
- R8: Mode code 5 (base with index) returns register `idx_a` plus register `idx_b` plus the sign-extended offset, with `out_mem` = 1. A zero offset gives plain base-plus-index.
- R9: Mode code 6 (post-increment) returns register `idx_a` as the address. `wb_data` is that register plus the step. Size codes 0, 1 and 2 give steps of 1, 2 and 4; size code 3 steps by 4.
- R10: Mode code 7 (pre-decrement) returns register `idx_a` minus the step (same step table as R9) as the address, and `wb_data` equals that address.
- R11: `wb_en` is high for exactly one cycle per request, and only for mode codes 6 and 7, together with `wb_idx` = the request's `idx_a`.
- R12: All address arithmetic wraps modulo 2^32, with no overflow indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| mode | input | 3 | Addressing mode code |
| idx_a | input | 4 | First register index (base / pointer) |
| idx_b | input | 4 | Second register index (index) |
| offset | input | 14 | Signed offset or address field |
| pc | input | 32 | Current program counter |
| size_code | input | 2 | Operand size: 0 byte, 1 half, 2 word, 3 word |
| rf_a_idx | output | 4 | Register-file read port A index |
| rf_a_data | input | 32 | Register-file read port A data |
| rf_b_idx | output | 4 | Register-file read port B index |
| rf_b_data | input | 32 | Register-file read port B data |
| out_valid | output | 1 | Result valid |
| out_value | output | 32 | Effective address or operand value |
| out_mem | output | 1 | 1 when `out_value` is a memory address |
| wb_en | output | 1 | Pointer write-back strobe |
| wb_idx | output | 4 | Register to update |
| wb_data | output | 32 | Updated pointer value |

## Verification
The bench targets the following corner cases:
- Negative offsets in the immediate, relative and index modes. A design that zero-extends them returns addresses near 16 K instead of just below the base.
- Every size code in the pointer modes, including the unused code 3. A wrong step table moves the pointer by the wrong amount.
- Pre-decrement, which must use the decremented value. A design that uses the old value addresses one element too high.
- Pointer and sum wrap-around past 2^32. Extra carry handling would show up here.
- Non-pointer modes and idle cycles. A write-back strobe that fires on these, or lasts two cycles, corrupts the register file.

// File: rtl/eagu_pkg.sv
package eagu_pkg;
   typedef enum logic [2:0] {
      EA_IMM  = 3'd0,
      EA_REG  = 3'd1,
      EA_ABS  = 3'd2,
      EA_REL  = 3'd3,
      EA_IDX  = 3'd4,
      EA_BIX  = 3'd5,
      EA_AINC = 3'd6,
      EA_ADEC = 3'd7
   } ea_mode_e;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } ea_size_e;
endpackage

// File: rtl/eagu_ext.sv
module eagu_ext #(
   parameter int IN_W  = 14,
   parameter int OUT_W = 32
) (
   input  logic [IN_W-1:0]  fld,
   output logic [OUT_W-1:0] sx,
   output logic [OUT_W-1:0] zx
);
   localparam int PAD_W = OUT_W - IN_W;

   if (IN_W > OUT_W) begin : g_bad_width
      $error("eagu_ext: field wider than result");
   end

   generate
      if (PAD_W == 0) begin : g_same
         assign sx = fld;
         assign zx = fld;
      end else begin : g_pad
         assign sx = {{PAD_W{fld[IN_W-1]}}, fld};
         assign zx = {{PAD_W{1'b0}}, fld};
      end
   endgenerate
endmodule

// File: rtl/eagu_step.sv
module eagu_step #(
   parameter int ADDR_W = 32
) (
   input  logic [1:0]        size_code,
   output logic [ADDR_W-1:0] step
);
   import eagu_pkg::*;

   if (ADDR_W < 3) begin : g_bad_width
      $error("eagu_step: address too narrow for a step of 4");
   end

   always_comb begin
      unique case (ea_size_e'(size_code))
         SZ_BYTE: step = ADDR_W'(1);
         SZ_HALF: step = ADDR_W'(2);
         default: step = ADDR_W'(4);
      endcase
   end
endmodule

// File: rtl/eagu_calc.sv
module eagu_calc #(
   parameter int ADDR_W = 32
) (
   input  logic [2:0]        mode,
   input  logic [ADDR_W-1:0] reg_a,
   input  logic [ADDR_W-1:0] reg_b,
   input  logic [ADDR_W-1:0] pc,
   input  logic [ADDR_W-1:0] ofs_s,
   input  logic [ADDR_W-1:0] ofs_z,
   input  logic [ADDR_W-1:0] step,
   output logic [ADDR_W-1:0] value,
   output logic              is_mem,
   output logic              do_wb,
   output logic [ADDR_W-1:0] wb_val
);
   import eagu_pkg::*;

   logic [ADDR_W-1:0] base_sel;
   logic [ADDR_W-1:0] sum_a_ofs;
   logic [ADDR_W-1:0] ptr_up;
   logic [ADDR_W-1:0] ptr_dn;

   assign base_sel  = (ea_mode_e'(mode) == EA_REL) ? pc : reg_a;
   assign sum_a_ofs = base_sel + ofs_s;
   assign ptr_up    = reg_a + step;
   assign ptr_dn    = reg_a - step;

   always_comb begin
      value  = '0;
      is_mem = 1'b1;
      do_wb  = 1'b0;
      wb_val = '0;
      unique case (ea_mode_e'(mode))
         EA_IMM: begin
            value  = ofs_s;
            is_mem = 1'b0;
         end
         EA_REG: begin
            value  = reg_a;
            is_mem = 1'b0;
         end
         EA_ABS:  value = ofs_z;
         EA_REL:  value = sum_a_ofs;
         EA_IDX:  value = sum_a_ofs;
         EA_BIX:  value = sum_a_ofs + reg_b;
         EA_AINC: begin
            value  = reg_a;
            do_wb  = 1'b1;
            wb_val = ptr_up;
         end
         EA_ADEC: begin
            value  = ptr_dn;
            do_wb  = 1'b1;
            wb_val = ptr_dn;
         end
         default: value = '0;
      endcase
   end
endmodule

// File: rtl/eagu_top.sv
module eagu_top #(
   parameter int ADDR_W = 32,
   parameter int OFS_W  = 14,
   parameter int IDX_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [2:0]        mode,
   input  logic [IDX_W-1:0]  idx_a,
   input  logic [IDX_W-1:0]  idx_b,
   input  logic [OFS_W-1:0]  offset,
   input  logic [ADDR_W-1:0] pc,
   input  logic [1:0]        size_code,
   output logic [IDX_W-1:0]  rf_a_idx,
   input  logic [ADDR_W-1:0] rf_a_data,
   output logic [IDX_W-1:0]  rf_b_idx,
   input  logic [ADDR_W-1:0] rf_b_data,
   output logic              out_valid,
   output logic [ADDR_W-1:0] out_value,
   output logic              out_mem,
   output logic              wb_en,
   output logic [IDX_W-1:0]  wb_idx,
   output logic [ADDR_W-1:0] wb_data
);
   if (OFS_W < 2 || OFS_W > ADDR_W) begin : g_bad_ofs
      $error("eagu_top: OFS_W must lie in 2..ADDR_W");
   end
   if (IDX_W < 1) begin : g_bad_idx
      $error("eagu_top: IDX_W must be at least 1");
   end

   logic [ADDR_W-1:0] ofs_s;
   logic [ADDR_W-1:0] ofs_z;
   logic [ADDR_W-1:0] step;
   logic [ADDR_W-1:0] nx_value;
   logic              nx_mem;
   logic              nx_wb;
   logic [ADDR_W-1:0] nx_wb_val;

   assign rf_a_idx = idx_a;
   assign rf_b_idx = idx_b;

   eagu_ext #(.IN_W(OFS_W), .OUT_W(ADDR_W)) u_ext (
      .fld (offset),
      .sx  (ofs_s),
      .zx  (ofs_z)
   );

   eagu_step #(.ADDR_W(ADDR_W)) u_step (
      .size_code (size_code),
      .step      (step)
   );

   eagu_calc #(.ADDR_W(ADDR_W)) u_calc (
      .mode   (mode),
      .reg_a  (rf_a_data),
      .reg_b  (rf_b_data),
      .pc     (pc),
      .ofs_s  (ofs_s),
      .ofs_z  (ofs_z),
      .step   (step),
      .value  (nx_value),
      .is_mem (nx_mem),
      .do_wb  (nx_wb),
      .wb_val (nx_wb_val)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_value <= '0;
         out_mem   <= 1'b0;
         wb_en     <= 1'b0;
         wb_idx    <= '0;
         wb_data   <= '0;
      end else begin
         out_valid <= req_valid;
         wb_en     <= req_valid & nx_wb;
         if (req_valid) begin
            out_value <= nx_value;
            out_mem   <= nx_mem;
            wb_idx    <= idx_a;
            wb_data   <= nx_wb_val;
         end
      end
   end
endmodule

// File: rtl/eagu_chk.sv
module eagu_chk #(
   parameter int ADDR_W = 32,
   parameter int OFS_W  = 14,
   parameter int IDX_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [2:0]        mode,
   input logic [IDX_W-1:0]  idx_a,
   input logic [OFS_W-1:0]  offset,
   input logic [1:0]        size_code,
   input logic [ADDR_W-1:0] rf_a_data,
   input logic              out_valid,
   input logic [ADDR_W-1:0] out_value,
   input logic              out_mem,
   input logic              wb_en,
   input logic [IDX_W-1:0]  wb_idx,
   input logic [ADDR_W-1:0] wb_data
);
   logic [ADDR_W-1:0] ofs_wide;
   assign ofs_wide = ADDR_W'($signed(offset));

   a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> out_valid);
   a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !out_valid && !wb_en);
   a_r3_imm_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && mode == 3'd0 |=> !out_mem);
   a_r7_index_sum: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && mode == 3'd4 |=> out_value == $past(rf_a_data) + $past(ofs_wide));
   a_r9_ainc_word: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && mode == 3'd6 && size_code == 2'd2 |=> wb_data == out_value + ADDR_W'(4));
   a_r10_adec_match: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && mode == 3'd7 |=> wb_data == out_value);
   a_r11_wb_only_ptr: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && mode != 3'd6 && mode != 3'd7 |=> !wb_en);
   a_r11_wb_target: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && (mode == 3'd6 || mode == 3'd7) |=> wb_en && wb_idx == $past(idx_a));
endmodule

bind eagu_top eagu_chk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/eagu_top_tb_top.sv
module eagu_top_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 18;

   typedef struct packed {
      logic [2:0]  m;
      logic [3:0]  ia;
      logic [3:0]  ib;
      logic [13:0] ofs;
      logic [1:0]  sz;
      logic [31:0] pc;
      logic [31:0] ev;
      logic        em;
      logic        ew;
      logic [31:0] ewd;
      logic [7:0]  rq;
   } vec_t;

   // register file model: reg i holds i*0x1000, reg 15 holds 0xFFFFFFFE
   localparam vec_t VEC [NV] = '{
      '{3'd0, 4'd0, 4'd0, 14'h3FFF, 2'd0, 32'h0,   32'hFFFF_FFFF, 1'b0, 1'b0, 32'h0,         8'd3},  // R3 negative
      '{3'd0, 4'd0, 4'd0, 14'h1FFF, 2'd0, 32'h0,   32'h0000_1FFF, 1'b0, 1'b0, 32'h0,         8'd3},  // R3 positive
      '{3'd1, 4'd3, 4'd0, 14'h0,    2'd0, 32'h0,   32'h0000_3000, 1'b0, 1'b0, 32'h0,         8'd4},  // R4
      '{3'd2, 4'd0, 4'd0, 14'h3FFF, 2'd0, 32'h0,   32'h0000_3FFF, 1'b1, 1'b0, 32'h0,         8'd5},  // R5 zero-ext
      '{3'd3, 4'd0, 4'd0, 14'h3FF0, 2'd0, 32'h100, 32'h0000_00F0, 1'b1, 1'b0, 32'h0,         8'd6},  // R6 backward
      '{3'd3, 4'd0, 4'd0, 14'h0020, 2'd0, 32'h100, 32'h0000_0120, 1'b1, 1'b0, 32'h0,         8'd6},  // R6 forward
      '{3'd4, 4'd2, 4'd0, 14'h3FFC, 2'd0, 32'h0,   32'h0000_1FFC, 1'b1, 1'b0, 32'h0,         8'd7},  // R7 negative
      '{3'd4, 4'd5, 4'd0, 14'h0,    2'd0, 32'h0,   32'h0000_5000, 1'b1, 1'b0, 32'h0,         8'd7},  // R7 indirect
      '{3'd5, 4'd1, 4'd2, 14'h0,    2'd0, 32'h0,   32'h0000_3000, 1'b1, 1'b0, 32'h0,         8'd8},  // R8 plain
      '{3'd5, 4'd4, 4'd6, 14'h0010, 2'd0, 32'h0,   32'h0000_A010, 1'b1, 1'b0, 32'h0,         8'd8},  // R8 offset
      '{3'd6, 4'd7, 4'd0, 14'h0,    2'd0, 32'h0,   32'h0000_7000, 1'b1, 1'b1, 32'h0000_7001, 8'd9},  // R9 byte
      '{3'd6, 4'd7, 4'd0, 14'h0,    2'd1, 32'h0,   32'h0000_7000, 1'b1, 1'b1, 32'h0000_7002, 8'd9},  // R9 half
      '{3'd6, 4'd7, 4'd0, 14'h0,    2'd2, 32'h0,   32'h0000_7000, 1'b1, 1'b1, 32'h0000_7004, 8'd9},  // R9 word
      '{3'd6, 4'd7, 4'd0, 14'h0,    2'd3, 32'h0,   32'h0000_7000, 1'b1, 1'b1, 32'h0000_7004, 8'd9},  // R9 code 3
      '{3'd7, 4'd8, 4'd0, 14'h0,    2'd2, 32'h0,   32'h0000_7FFC, 1'b1, 1'b1, 32'h0000_7FFC, 8'd10}, // R10 word
      '{3'd7, 4'd0, 4'd0, 14'h0,    2'd0, 32'h0,   32'hFFFF_FFFF, 1'b1, 1'b1, 32'hFFFF_FFFF, 8'd12}, // R12 dec wrap
      '{3'd6, 4'd15,4'd0, 14'h0,    2'd2, 32'h0,   32'hFFFF_FFFE, 1'b1, 1'b1, 32'h0000_0002, 8'd12}, // R12 inc wrap
      '{3'd5, 4'd15,4'd15,14'h0004, 2'd0, 32'h0,   32'h0000_0000, 1'b1, 1'b0, 32'h0,         8'd12}  // R12 sum wrap
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  mode = '0;
   logic [3:0]  idx_a = '0;
   logic [3:0]  idx_b = '0;
   logic [13:0] offset = '0;
   logic [31:0] pc = '0;
   logic [1:0]  size_code = '0;
   logic [3:0]  rf_a_idx;
   logic [3:0]  rf_b_idx;
   logic [31:0] rf_a_data;
   logic [31:0] rf_b_data;
   logic        out_valid;
   logic [31:0] out_value;
   logic        out_mem;
   logic        wb_en;
   logic [3:0]  wb_idx;
   logic [31:0] wb_data;

   int checks = 0;
   int errors = 0;

   function automatic logic [31:0] rf_model(input logic [3:0] i);
      return (i == 4'd15) ? 32'hFFFF_FFFE : {16'h0, i, 12'h000};
   endfunction

   assign rf_a_data = rf_model(rf_a_idx);
   assign rf_b_data = rf_model(rf_b_idx);

   always #(CLK_PERIOD/2) clk = ~clk;

   eagu_top dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode),
      .idx_a(idx_a), .idx_b(idx_b), .offset(offset), .pc(pc),
      .size_code(size_code), .rf_a_idx(rf_a_idx), .rf_a_data(rf_a_data),
      .rf_b_idx(rf_b_idx), .rf_b_data(rf_b_data), .out_valid(out_valid),
      .out_value(out_value), .out_mem(out_mem), .wb_en(wb_en),
      .wb_idx(wb_idx), .wb_data(wb_data)
   );

   task automatic chk(input bit ok, input int rq, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL R%0d %s actual=%h expected=%h", rq, what, act, exp);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs quiet during reset
      chk(out_valid == 1'b0 && wb_en == 1'b0 && out_mem == 1'b0, 1, "reset flags",
          {29'h0, out_valid, wb_en, out_mem}, 32'h0);
      chk(out_value == 32'h0 && wb_data == 32'h0, 1, "reset data", out_value | wb_data, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: first cycle after reset with no request
      chk(out_valid == 1'b0 && wb_en == 1'b0, 1, "post-reset idle",
          {30'h0, out_valid, wb_en}, 32'h0);

      for (int k = 0; k < NV; k++) begin
         mode = VEC[k].m; idx_a = VEC[k].ia; idx_b = VEC[k].ib;
         offset = VEC[k].ofs; size_code = VEC[k].sz; pc = VEC[k].pc;
         req_valid = 1'b1;
         @(negedge clk);
         // R2: valid follows request
         chk(out_valid == 1'b1, 2, "valid", {31'h0, out_valid}, 32'h1);
         chk(out_value == VEC[k].ev, int'(VEC[k].rq), "value", out_value, VEC[k].ev);
         chk(out_mem == VEC[k].em, int'(VEC[k].rq), "mem flag", {31'h0, out_mem}, {31'h0, VEC[k].em});
         // R11: strobe only in pointer modes
         chk(wb_en == VEC[k].ew, 11, "wb_en", {31'h0, wb_en}, {31'h0, VEC[k].ew});
         if (VEC[k].ew) begin
            chk(wb_data == VEC[k].ewd, int'(VEC[k].rq), "wb_data", wb_data, VEC[k].ewd);
            chk(wb_idx == VEC[k].ia, 11, "wb_idx", {28'h0, wb_idx}, {28'h0, VEC[k].ia});
         end
      end

      // R11: single-cycle strobe after a pointer request, then idle (R2)
      mode = 3'd6; idx_a = 4'd9; size_code = 2'd1; req_valid = 1'b1;
      @(negedge clk);
      chk(wb_en == 1'b1 && wb_data == 32'h0000_9002, 11, "ptr strobe", wb_data, 32'h0000_9002);
      req_valid = 1'b0;
      @(negedge clk);
      chk(wb_en == 1'b0, 11, "strobe one cycle", {31'h0, wb_en}, 32'h0);
      chk(out_valid == 1'b0, 2, "idle valid", {31'h0, out_valid}, 32'h0);

      // R1: reset in mid-stream clears the strobe
      mode = 3'd7; idx_a = 4'd3; req_valid = 1'b1;
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk(wb_en == 1'b0 && out_valid == 1'b0 && out_value == 32'h0, 1, "async reset",
          out_value, 32'h0);
      req_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      checks++;
      errors++;
      $display("FAIL R2 watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule